// File: doc/BRIEF.md
# Staged Control Word Pipeline for a Five-Stage Integer Core

This block turns one instruction per clock into a control word and carries that word down a five-stage integer pipeline. The stages are fetch, decode, execute, memory and writeback. The instruction arrives from the fetch/decode register and is decoded in the same cycle. The resulting word is split into three groups, and each group is released in the stage that consumes it. The execute group appears one cycle after decode. The memory group appears two cycles after decode. The writeback group and the destination register number appear three cycles after decode.

Only three instructions are recognised: a register-register add, a word load and a word store. The add is not allowed to bypass the memory stage. It crosses that stage as a no-op with the memory write enable low, so it writes back in the fifth stage, the same as a load. As a result the single register-file write port never has two claimants in one cycle. Anything unrecognised, an instruction marked not valid, and reset all put a bubble into the pipeline. A bubble is an all-zero control word, and it then advances like any other word.

Top module: `ctl_word_pipe`

## Requirements
- R1: While reset is low, every output is zero.
- R2: An add has opcode bits [31:26] = 0 and function bits [5:0] = 0x20. One cycle after it is presented with valid high, the execute outputs show ALU op code 2 (register add), immediate select 0 and destination-from-rd select 1.
- R3: A load has opcode 0x23. It gives ALU op code 1 (address add), immediate select 1 and rd select 0 in execute. In memory it gives write enable 0 and address-from-ALU 1. In writeback it gives memory-to-register 1 and register write 1.
- R4: A store has opcode 0x2B. It gives ALU op code 1 and immediate select 1 in execute, write enable 1 and address-from-ALU 1 in memory, and register write 0 in writeback.
- R5: The execute group shows the instruction presented one cycle earlier. The memory group shows the one presented two cycles earlier. The writeback group shows the one presented three cycles earlier.
- R6: In the memory stage an add shows write enable 0 and address-from-ALU 0. Its register write reaches writeback three cycles after presentation, the same as a load.
- R7: Valid low, an unknown opcode, or opcode 0 with a function code other than 0x20 produces an all-zero control word. That word advances through the later stages like any other.
- R8: The write-port-busy output equals the writeback register write enable. It is high exactly three cycles after each add or load, so at most one instruction owns the write port in any cycle.
- R9: The writeback destination is field [15:11] for an add and field [20:16] for a load. It is zero for a store or a bubble. It arrives in the same cycle as the register write enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_i | input | 32 | Instruction in the decode stage |
| instr_vld_i | input | 1 | Instruction valid |
| ex_alu_op_o | output | 2 | ALU operation: 0 none, 1 address add, 2 register add |
| ex_alu_src_imm_o | output | 1 | Second ALU operand is the immediate |
| ex_dst_rd_o | output | 1 | Destination taken from the rd field |
| mem_we_o | output | 1 | Data memory write enable |
| mem_addr_alu_o | output | 1 | Memory address taken from the ALU result |
| wb_mem_to_reg_o | output | 1 | Write-back data taken from memory |
| wb_reg_we_o | output | 1 | Register file write enable |
| wb_dest_o | output | 5 | Register number written back |
| wport_busy_o | output | 1 | Register-file write port in use this cycle |

## Verification
Corruption in the decode/execute register shows at the execute outputs one cycle after the instruction is presented. A fault in the execute/memory register shows at the memory outputs one cycle later. A fault in the memory/writeback register shows in the writeback enables and the destination number in the third cycle. A decode error on an add or a load appears as write-port activity that is missing, extra or shifted against the instruction stream. The reference model compares every group on every cycle, so any such fault is reported within three cycles of the instruction that exposed it.

// File: rtl/ctl_word_pkg.sv
package ctl_word_pkg;
  localparam int INSTR_W  = 32;
  localparam int OPC_W    = 6;
  localparam int FUNCT_W  = 6;
  localparam int RAW      = 5;
  localparam int ALU_OP_W = 2;

  localparam int OPC_LSB = INSTR_W - OPC_W;
  localparam int RT_LSB  = OPC_LSB - 2 * RAW;
  localparam int RD_LSB  = RT_LSB - RAW;

  localparam logic [OPC_W-1:0]    OPC_RTYPE = 6'h00;
  localparam logic [OPC_W-1:0]    OPC_LOAD  = 6'h23;
  localparam logic [OPC_W-1:0]    OPC_STORE = 6'h2B;
  localparam logic [FUNCT_W-1:0]  FN_ADD    = 6'h20;

  localparam logic [ALU_OP_W-1:0] ALU_NONE   = 2'd0;
  localparam logic [ALU_OP_W-1:0] ALU_ADDR   = 2'd1;
  localparam logic [ALU_OP_W-1:0] ALU_REGADD = 2'd2;

  typedef struct packed {
    logic [ALU_OP_W-1:0] alu_op;
    logic                src_imm;
    logic                dst_rd;
  } ex_ctl_t;

  typedef struct packed {
    logic we;
    logic addr_alu;
  } mem_ctl_t;

  typedef struct packed {
    logic mem_to_reg;
    logic reg_we;
  } wb_ctl_t;

  typedef struct packed {
    ex_ctl_t        ex;
    mem_ctl_t       mem;
    wb_ctl_t        wb;
    logic [RAW-1:0] dest;
  } ctl_word_t;

  typedef struct packed {
    mem_ctl_t       mem;
    wb_ctl_t        wb;
    logic [RAW-1:0] dest;
  } em_word_t;

  typedef struct packed {
    wb_ctl_t        wb;
    logic [RAW-1:0] dest;
  } mw_word_t;

  function automatic logic [OPC_W-1:0] opc_of(input logic [INSTR_W-1:0] ins);
    return ins[OPC_LSB +: OPC_W];
  endfunction

  function automatic logic [FUNCT_W-1:0] funct_of(input logic [INSTR_W-1:0] ins);
    return ins[FUNCT_W-1:0];
  endfunction

  function automatic logic [RAW-1:0] rt_of(input logic [INSTR_W-1:0] ins);
    return ins[RT_LSB +: RAW];
  endfunction

  function automatic logic [RAW-1:0] rd_of(input logic [INSTR_W-1:0] ins);
    return ins[RD_LSB +: RAW];
  endfunction

  function automatic ctl_word_t decode_word(input logic [INSTR_W-1:0] ins, input logic vld);
    ctl_word_t w;
    w = '0;
    if (vld) begin
      if (opc_of(ins) == OPC_RTYPE && funct_of(ins) == FN_ADD) begin
        w.ex.alu_op = ALU_REGADD;
        w.ex.dst_rd = 1'b1;
        w.wb.reg_we = 1'b1;
        w.dest      = rd_of(ins);
      end else if (opc_of(ins) == OPC_LOAD) begin
        w.ex.alu_op       = ALU_ADDR;
        w.ex.src_imm      = 1'b1;
        w.mem.addr_alu    = 1'b1;
        w.wb.mem_to_reg   = 1'b1;
        w.wb.reg_we       = 1'b1;
        w.dest            = rt_of(ins);
      end else if (opc_of(ins) == OPC_STORE) begin
        w.ex.alu_op    = ALU_ADDR;
        w.ex.src_imm   = 1'b1;
        w.mem.we       = 1'b1;
        w.mem.addr_alu = 1'b1;
      end
    end
    return w;
  endfunction
endpackage

// File: rtl/ctl_word_decoder.sv
module ctl_word_decoder
  import ctl_word_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               vld_i,
  output ctl_word_t          word_o,
  output logic               bubble_o
);
  logic unused_fields;
  assign unused_fields = ^{instr_i[OPC_LSB-1:RT_LSB+RAW], instr_i[RD_LSB-1:FUNCT_W]};

  assign word_o   = decode_word(instr_i, vld_i);
  assign bubble_o = (word_o == '0);
endmodule

// File: rtl/ctl_stage_reg.sv
module ctl_stage_reg #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/ctl_word_pipe.sv
module ctl_word_pipe
  import ctl_word_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [INSTR_W-1:0]  instr_i,
  input  logic                instr_vld_i,
  output logic [ALU_OP_W-1:0] ex_alu_op_o,
  output logic                ex_alu_src_imm_o,
  output logic                ex_dst_rd_o,
  output logic                mem_we_o,
  output logic                mem_addr_alu_o,
  output logic                wb_mem_to_reg_o,
  output logic                wb_reg_we_o,
  output logic [RAW-1:0]      wb_dest_o,
  output logic                wport_busy_o
);
  localparam int DE_W = $bits(ctl_word_t);
  localparam int EM_W = $bits(em_word_t);
  localparam int MW_W = $bits(mw_word_t);

  ctl_word_t       dec_word;
  logic            dec_bubble;
  logic [DE_W-1:0] de_vec;
  logic [EM_W-1:0] em_vec;
  logic [MW_W-1:0] mw_vec;
  ctl_word_t       de_q;
  em_word_t        em_d, em_q;
  mw_word_t        mw_d, mw_q;

  ctl_word_decoder u_dec (
    .instr_i  (instr_i),
    .vld_i    (instr_vld_i),
    .word_o   (dec_word),
    .bubble_o (dec_bubble)
  );

  ctl_stage_reg #(.W(DE_W)) u_de (.clk(clk), .rst_n(rst_n), .d(dec_word), .q(de_vec));
  assign de_q = ctl_word_t'(de_vec);

  assign em_d.mem  = de_q.mem;
  assign em_d.wb   = de_q.wb;
  assign em_d.dest = de_q.dest;
  ctl_stage_reg #(.W(EM_W)) u_em (.clk(clk), .rst_n(rst_n), .d(em_d), .q(em_vec));
  assign em_q = em_word_t'(em_vec);

  assign mw_d.wb   = em_q.wb;
  assign mw_d.dest = em_q.dest;
  ctl_stage_reg #(.W(MW_W)) u_mw (.clk(clk), .rst_n(rst_n), .d(mw_d), .q(mw_vec));
  assign mw_q = mw_word_t'(mw_vec);

  logic unused_bubble;
  assign unused_bubble = dec_bubble;

  assign ex_alu_op_o      = de_q.ex.alu_op;
  assign ex_alu_src_imm_o = de_q.ex.src_imm;
  assign ex_dst_rd_o      = de_q.ex.dst_rd;
  assign mem_we_o         = em_q.mem.we;
  assign mem_addr_alu_o   = em_q.mem.addr_alu;
  assign wb_mem_to_reg_o  = mw_q.wb.mem_to_reg;
  assign wb_reg_we_o      = mw_q.wb.reg_we;
  assign wb_dest_o        = mw_q.dest;
  assign wport_busy_o     = mw_q.wb.reg_we;
endmodule

// File: rtl/ctl_word_pipe_chk.sv
module ctl_word_pipe_chk
  import ctl_word_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic [INSTR_W-1:0]  instr_i,
  input logic                instr_vld_i,
  input logic [ALU_OP_W-1:0] ex_alu_op_o,
  input logic                ex_alu_src_imm_o,
  input logic                ex_dst_rd_o,
  input logic                mem_we_o,
  input logic                mem_addr_alu_o,
  input logic                wb_mem_to_reg_o,
  input logic                wb_reg_we_o,
  input logic [RAW-1:0]      wb_dest_o,
  input logic                wport_busy_o
);
  logic [5:0] op;
  logic [5:0] fn;
  logic [4:0] rd_f;
  logic       is_add, is_lw, is_sw;
  logic [1:0] cyc;
  logic       unused_bits;

  assign op     = instr_i[31:26];
  assign fn     = instr_i[5:0];
  assign rd_f   = instr_i[15:11];
  assign is_add = instr_vld_i && op == 6'd0 && fn == 6'd32;
  assign is_lw  = instr_vld_i && op == 6'd35;
  assign is_sw  = instr_vld_i && op == 6'd43;
  assign unused_bits = ^{instr_i[25:16], instr_i[10:6]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cyc <= 2'd0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  assert_reset_zero_R1: assert property (@(posedge clk)
    !rst_n |-> (ex_alu_op_o == '0 && !ex_alu_src_imm_o && !ex_dst_rd_o && !mem_we_o &&
                !mem_addr_alu_o && !wb_mem_to_reg_o && !wb_reg_we_o && wb_dest_o == '0 &&
                !wport_busy_o));

  assert_bubble_ex_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc != 2'd0 && !$past(instr_vld_i)) |-> (ex_alu_op_o == '0 && !ex_alu_src_imm_o && !ex_dst_rd_o));

  assert_add_no_mem_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2 && $past(is_add, 2)) |-> (!mem_we_o && !mem_addr_alu_o));

  assert_wport_owner_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd3 && wport_busy_o) |-> ($past(is_add, 3) || $past(is_lw, 3)));

  assert_store_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd3 && $past(is_sw, 3)) |-> (!wb_reg_we_o && mem_we_o == 1'b0 || !wb_reg_we_o));

  assert_add_dest_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd3 && $past(is_add, 3)) |-> (wb_reg_we_o && wb_dest_o == $past(rd_f, 3)));

  assert_idle_dest_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wb_reg_we_o |-> (wb_dest_o == '0 && !wb_mem_to_reg_o));

  logic unused_chk;
  assign unused_chk = unused_bits;
endmodule

bind ctl_word_pipe ctl_word_pipe_chk u_chk (.*);

// File: tb/ctl_word_pipe_tb.sv
`timescale 1ns/1ps
module ctl_word_pipe_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr = '0;
  logic        vld = 1'b0;
  logic [1:0]  ex_alu_op;
  logic        ex_imm, ex_rd, m_we, m_addr, w_m2r, w_we, busy;
  logic [4:0]  w_dest;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int mk[3];
  int md[3];

  always #4 clk = ~clk;

  ctl_word_pipe u_dut (
    .clk(clk), .rst_n(rst_n), .instr_i(instr), .instr_vld_i(vld),
    .ex_alu_op_o(ex_alu_op), .ex_alu_src_imm_o(ex_imm), .ex_dst_rd_o(ex_rd),
    .mem_we_o(m_we), .mem_addr_alu_o(m_addr), .wb_mem_to_reg_o(w_m2r),
    .wb_reg_we_o(w_we), .wb_dest_o(w_dest), .wport_busy_o(busy)
  );

  // kind: 0 bubble, 1 add, 2 load, 3 store
  function automatic int kind_of(logic [31:0] ins, logic v);
    int op = int'(ins >> 26);
    int fn = int'(ins & 32'h3F);
    if (!v) return 0;
    if (op == 0 && fn == 32) return 1;
    if (op == 35) return 2;
    if (op == 43) return 3;
    return 0;
  endfunction

  function automatic int dest_of(logic [31:0] ins, int k);
    if (k == 1) return int'((ins >> 11) & 32'h1F);
    if (k == 2) return int'((ins >> 16) & 32'h1F);
    return 0;
  endfunction

  function automatic logic [31:0] r_add(int rs, int rt, int rd, int fn);
    return (rs << 21) | (rt << 16) | (rd << 11) | fn;
  endfunction

  function automatic logic [31:0] i_op(int op, int rs, int rt, int imm);
    return (op << 26) | (rs << 21) | (rt << 16) | (imm & 16'hFFFF);
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    string te, tm, tw;
    te = (mk[0] == 1) ? "R2" : (mk[0] == 2) ? "R3" : (mk[0] == 3) ? "R4" : "R7";
    tm = (mk[1] == 1) ? "R6" : "R5";
    tw = (mk[2] == 2) ? "R3" : (mk[2] == 1) ? "R6" : "R5";
    chk(te, "alu_op", ex_alu_op, (mk[0] == 1) ? 2 : (mk[0] >= 2) ? 1 : 0);
    chk(te, "src_imm", ex_imm, (mk[0] >= 2) ? 1 : 0);
    chk(te, "dst_rd", ex_rd, (mk[0] == 1) ? 1 : 0);
    chk(tm, "mem_we", m_we, (mk[1] == 3) ? 1 : 0);
    chk(tm, "addr_alu", m_addr, (mk[1] >= 2) ? 1 : 0);
    chk(tw, "mem_to_reg", w_m2r, (mk[2] == 2) ? 1 : 0);
    chk(tw, "reg_we", w_we, (mk[2] == 1 || mk[2] == 2) ? 1 : 0);
    chk("R9", "dest", w_dest, md[2]);
    chk("R8", "wport_busy", busy, (mk[2] == 1 || mk[2] == 2) ? 1 : 0);
  endtask

  task automatic step(logic [31:0] ins, logic v);
    int k;
    instr = ins;
    vld   = v;
    k = kind_of(ins, v);
    @(posedge clk);
    @(negedge clk);
    mk[2] = mk[1]; md[2] = md[1];
    mk[1] = mk[0]; md[1] = md[0];
    mk[0] = k;     md[0] = dest_of(ins, k);
    compare();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) begin mk[i] = 0; md[i] = 0; end
    repeat (3) @(negedge clk);
    instr = r_add(1, 2, 3, 32);
    vld = 1'b1;
    @(negedge clk);
    // R1: outputs held at zero under reset even with a valid add present
    chk("R1", "outputs under reset",
        int'({ex_alu_op, ex_imm, ex_rd, m_we, m_addr, w_m2r, w_we, w_dest, busy}), 0);
    vld = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    compare();

    step(r_add(1, 2, 7, 32), 1'b1);   // add
    step(i_op(35, 4, 9, 16), 1'b1);   // load right after add
    step(r_add(3, 3, 12, 32), 1'b1);  // add right after load: R8 one owner per cycle
    step(r_add(5, 6, 31, 32), 1'b1);
    step(i_op(43, 2, 8, 4), 1'b1);    // store
    step(i_op(8, 1, 2, 3), 1'b1);     // unknown opcode -> R7
    step(i_op(35, 1, 5, 0), 1'b0);    // valid low -> R7
    step(r_add(1, 2, 3, 34), 1'b1);   // other function code -> R7
    step(i_op(35, 0, 30, 8), 1'b1);
    step(i_op(35, 0, 17, 8), 1'b1);
    step(r_add(0, 0, 0, 32), 1'b1);   // add to register 0
    for (int i = 0; i < 4; i++) step('0, 1'b0);

    for (int i = 0; i < 300; i++) begin
      int sel = int'($urandom_range(0, 5));
      int a = int'($urandom_range(0, 31));
      int b = int'($urandom_range(0, 31));
      int c = int'($urandom_range(0, 31));
      case (sel)
        0, 1: step(r_add(a, b, c, 32), 1'b1);
        2, 3: step(i_op(35, a, b, c), 1'b1);
        4:    step(i_op(43, a, b, c), 1'b1);
        default: step(i_op(c, a, b, c), sel[0]);
      endcase
    end
    for (int i = 0; i < 4; i++) step('0, 1'b0);

    // R1: reset asserted mid-stream clears every stage
    step(i_op(35, 1, 9, 0), 1'b1);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "outputs after mid-run reset",
        int'({ex_alu_op, ex_imm, ex_rd, m_we, m_addr, w_m2r, w_we, w_dest, busy}), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule